// File: doc/BRIEF.md
# Multi-Port Shared Memory Arbiter

This block sits in front of a single-port word memory and lets up to four processor ports share it. In each cycle the array performs at most one access, a read or a write, and an arbiter picks which requesting port gets it. Every port can be switched off, given one of two priority levels, and set to one of three address sources: the address carried with the request, a private address generator, or a latched address loaded by an earlier transfer.

A request is held on a port until its ready bit rises. Ready is combinational in the cycle of the grant. Write data lands in the array at that clock edge. Read data comes back on a shared read bus one cycle later, with a valid bit raised only on the port that asked for it. Among the competing ports at the highest active priority level, the port that has waited longest since its last service wins. The memory depth is set by the address width. The default of 11 bits gives 2048 words, and a width of 13 gives an array of 8192 words of 16 bits.

Top module: `shmem_port_arbiter`

## Requirements
- R1: A port whose enable bit is 0 is never granted. Its requests raise no ready and no response, and its writes leave the memory unchanged.
- R2: At most one port wins the array in any cycle. Data written through one port reads back unchanged through another.
- R3: When ports of equal priority collide, the grant goes to the one served least recently. Out of reset, the assumed service age runs from port 0 (oldest) to the last port. When all four ports request continuously, the grants rotate 0,1,2,3,0,1,2,3.
- R4: When any enabled requesting port has its priority bit at 1 (high), no port with the bit at 0 is granted, however long that port has waited.
- R5: In generator mode (mode code 1), the access address is base plus offset. After each granted access, the offset moves by the signed stride and wraps modulo the wrap length, so it stays in the range 0 to length-1. A configuration load sets base, stride and length and clears the offset. The stride magnitude must be less than the length.
- R6: In split mode (mode code 2), a request with the address-phase bit set takes its address from the low bits of the write-data field. It is accepted in the same cycle without using the array, so another port can be granted in that cycle. Later data-phase reads and writes on that port use the latched address.
- R7: Read data appears on the read bus one cycle after the grant. The response-valid bit is raised only for the granted port. A write produces no response.
- R8: The service-age order changes only in cycles that issue a grant. Idle cycles leave it as it was.
- R9: After reset, no response is valid and no ready is raised while no request is present.
- R10: In direct mode (mode codes 0 and 3), the address is taken from the port's own address field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | NPORT | Per-port enable; 0 ties the port off |
| port_hi | input | NPORT | Per-port priority level, 1 = high |
| port_mode | input | 2*NPORT | Per-port address source: 0 direct, 1 generator, 2 split, 3 direct |
| cfg_load | input | NPORT | Load generator settings into the selected ports |
| cfg_base | input | AW | Generator base address |
| cfg_stride | input | AW | Generator signed stride |
| cfg_len | input | AW+1 | Generator wrap length |
| req_valid | input | NPORT | Request present |
| req_write | input | NPORT | 1 = write, 0 = read |
| req_addr_phase | input | NPORT | In split mode, marks an address transfer |
| req_addr | input | NPORT*AW | Per-port direct address |
| req_wdata | input | NPORT*DW | Per-port write data (split address in low bits) |
| req_ready | output | NPORT | Request accepted this cycle |
| rsp_valid | output | NPORT | Read data valid for this port |
| rsp_rdata | output | DW | Read data |

## Verification
A corrupted service-age matrix shows up at the ports as a wrong ready pattern on the very next collision. The rotation and idle-gap scenarios catch it within one cycle of the misordered grant. A generator offset that drifts or wraps wrongly puts a write at the wrong address. That only surfaces when the location is read back through a direct port, so each generator run is followed by a full read sweep of its window. A stale split-mode latch or a response steered to the wrong port is visible in the cycle after the grant, through the read data or the response-valid bits.

// File: rtl/shm_pkg.sv
// Shared definitions for the shared-memory port arbiter.
// Assumes: mode field is two bits per port.
package shm_pkg;
    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_AGEN   = 2'd1,
        MODE_SPLIT  = 2'd2,
        MODE_RSVD   = 2'd3
    } port_mode_e;
endpackage

// File: rtl/shm_agen.sv
// Per-port address generator: address = base + offset, offset steps by a
// signed stride and wraps modulo a length.
// Assumes: |stride| < length and length >= 1 whenever step is used.
module shm_agen #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] stride_in,
    input  logic [AW:0]   len_in,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam int SW = AW + 2;

    logic [AW-1:0] base_q, stride_q;
    logic [AW:0]   len_q, off_q, off_nxt;
    logic signed [SW-1:0] sum, lenx;

    // Next offset: add the stride, then fold back into the window.
    always_comb begin
        lenx = $signed({1'b0, len_q});
        sum  = $signed({1'b0, off_q}) + $signed({{2{stride_q[AW-1]}}, stride_q});
        if (sum < 0)
            sum = sum + lenx;
        else if (sum >= lenx)
            sum = sum - lenx;
        off_nxt = sum[AW:0];
    end

    // Settings and offset registers; a load takes precedence over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= AW'(1);
            len_q    <= (AW+1)'(1) << AW;
            off_q    <= '0;
        end else if (load) begin
            base_q   <= base_in;
            stride_q <= stride_in;
            len_q    <= len_in;
            off_q    <= '0;
        end else if (step) begin
            off_q    <= off_nxt;
        end
    end

    assign addr = base_q + off_q[AW-1:0];

    assert_offset_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != 0) |-> (off_q < len_q));
endmodule

// File: rtl/shm_lrs_arb.sv
// Two-level priority arbiter with least-recently-serviced tie-break.
// Keeps an age matrix: older_q[i][j] = 1 means port i was served before j.
// Assumes: req is already masked by the port enables.
module shm_lrs_arb #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req,
    input  logic [NPORT-1:0] hi,
    output logic [NPORT-1:0] gnt
);
    logic [NPORT-1:0][NPORT-1:0] older_q;
    logic [NPORT-1:0] elig;
    logic             any_hi;

    // Restrict candidates to the highest active priority level.
    always_comb begin
        any_hi = |(req & hi);
        elig   = any_hi ? (req & hi) : req;
    end

    // Winner: the candidate older than every other candidate.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            gnt[i] = elig[i];
            for (int j = 0; j < NPORT; j++)
                if (j != i && elig[j] && !older_q[i][j])
                    gnt[i] = 1'b0;
        end
    end

    // Age update: the winner becomes the most recently served port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPORT; i++)
                for (int j = 0; j < NPORT; j++)
                    older_q[i][j] <= (i < j);
        end else if (|gnt) begin
            for (int i = 0; i < NPORT; i++)
                for (int j = 0; j < NPORT; j++)
                    if (i != j) begin
                        if (gnt[i])      older_q[i][j] <= 1'b0;
                        else if (gnt[j]) older_q[i][j] <= 1'b1;
                    end
        end
    end

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_high_level_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & hi)) |-> ((gnt & ~hi) == '0));
    assert_age_holds_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> $stable(older_q));
endmodule

// File: rtl/shm_array.sv
// Behavioural single-port word array with a registered read port and a
// per-port response-valid vector.
// Assumes: gnt is one-hot or zero.
module shm_array #(
    parameter int NPORT = 4,
    parameter int AW    = 11,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] gnt,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [NPORT-1:0] rsp_valid,
    output logic [DW-1:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          acc;

    assign acc = |gnt;

    // Storage access: one write or one read per cycle.
    always_ff @(posedge clk) begin
        if (acc && we)
            mem[addr] <= wdata;
        else if (acc)
            rdata <= mem[addr];
    end

    // Response tag: flags the port whose read was just performed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_valid <= '0;
        else
            rsp_valid <= we ? '0 : gnt;
    end
endmodule

// File: rtl/shmem_port_arbiter.sv
// Shared-memory front end: up to NPORT ports share one single-port array.
// Each port chooses direct, generator or split addressing; one access is
// granted per cycle by a two-level priority, least-recently-served arbiter.
// Assumes: a port holds its request until req_ready.
module shmem_port_arbiter
    import shm_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 11,
    parameter int DW    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPORT-1:0]   port_en,
    input  logic [NPORT-1:0]   port_hi,
    input  logic [2*NPORT-1:0] port_mode,
    input  logic [NPORT-1:0]   cfg_load,
    input  logic [AW-1:0]      cfg_base,
    input  logic [AW-1:0]      cfg_stride,
    input  logic [AW:0]        cfg_len,
    input  logic [NPORT-1:0]   req_valid,
    input  logic [NPORT-1:0]   req_write,
    input  logic [NPORT-1:0]   req_addr_phase,
    input  logic [NPORT*AW-1:0] req_addr,
    input  logic [NPORT*DW-1:0] req_wdata,
    output logic [NPORT-1:0]   req_ready,
    output logic [NPORT-1:0]   rsp_valid,
    output logic [DW-1:0]      rsp_rdata
);
    logic [NPORT-1:0]         mem_req, ap_acc, gnt;
    logic [NPORT-1:0][AW-1:0] eff_addr;
    logic [AW-1:0]            sel_addr;
    logic [DW-1:0]            sel_wdata;
    logic                     sel_we;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_mode_e    mode;
        logic          split_sel;
        logic [AW-1:0] split_q, gen_addr;

        assign mode      = port_mode_e'(port_mode[2*p +: 2]);
        assign split_sel = (mode == MODE_SPLIT);
        assign ap_acc[p]  = req_valid[p] & port_en[p] & split_sel & req_addr_phase[p];
        assign mem_req[p] = req_valid[p] & port_en[p] & ~(split_sel & req_addr_phase[p]);
        assign eff_addr[p] = (mode == MODE_AGEN) ? gen_addr :
                             split_sel           ? split_q  : req_addr[p*AW +: AW];

        // Split-mode address latch, written by address-phase transfers.
        always_ff @(posedge clk) begin
            if (!rst_n)
                split_q <= '0;
            else if (ap_acc[p])
                split_q <= req_wdata[p*DW +: AW];
        end

        shm_agen #(.AW(AW)) i_agen (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (cfg_load[p]),
            .base_in   (cfg_base),
            .stride_in (cfg_stride),
            .len_in    (cfg_len),
            .step      (gnt[p] & (mode == MODE_AGEN)),
            .addr      (gen_addr)
        );
    end

    shm_lrs_arb #(.NPORT(NPORT)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mem_req),
        .hi    (port_hi),
        .gnt   (gnt)
    );

    // Access mux: route the granted port's address, data and direction.
    always_comb begin
        sel_addr  = '0;
        sel_wdata = '0;
        sel_we    = 1'b0;
        for (int p = 0; p < NPORT; p++)
            if (gnt[p]) begin
                sel_addr  = sel_addr  | eff_addr[p];
                sel_wdata = sel_wdata | req_wdata[p*DW +: DW];
                sel_we    = sel_we    | req_write[p];
            end
    end

    shm_array #(.NPORT(NPORT), .AW(AW), .DW(DW)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (gnt),
        .we        (sel_we),
        .addr      (sel_addr),
        .wdata     (sel_wdata),
        .rsp_valid (rsp_valid),
        .rdata     (rsp_rdata)
    );

    assign req_ready = gnt | ap_acc;

    assert_off_port_never_granted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~port_en) == '0);
    assert_response_follows_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |-> $past(|gnt));
endmodule

// File: tb/test_shmem_port_arbiter.sv
`timescale 1ns/1ps
module test_shmem_port_arbiter;
    localparam int P  = 4;
    localparam int AW = 11;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [P-1:0]    port_en, port_hi, cfg_load;
    logic [2*P-1:0]  port_mode;
    logic [AW-1:0]   cfg_base, cfg_stride;
    logic [AW:0]     cfg_len;
    logic [P-1:0]    req_valid, req_write, req_addr_phase;
    logic [P*AW-1:0] req_addr;
    logic [P*DW-1:0] req_wdata;
    logic [P-1:0]    req_ready, rsp_valid;
    logic [DW-1:0]   rsp_rdata;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] model [int];

    always #2 clk = ~clk;

    shmem_port_arbiter #(.NPORT(P), .AW(AW), .DW(DW)) i_shmem_port_arbiter (.*);

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle_all();
        req_valid = '0; req_write = '0; req_addr_phase = '0;
        req_addr = '0; req_wdata = '0; cfg_load = '0;
    endtask

    task automatic drive(int p, bit wr, bit ap, logic [AW-1:0] a, logic [DW-1:0] d);
        req_valid[p] = 1'b1; req_write[p] = wr; req_addr_phase[p] = ap;
        req_addr[p*AW +: AW] = a; req_wdata[p*DW +: DW] = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; idle_all();
        port_en = '1; port_hi = '0; port_mode = '0;
        cfg_base = '0; cfg_stride = '0; cfg_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One lone transfer: returns ready in the request cycle and the
    // response seen in the next cycle.
    task automatic xfer(int p, bit wr, bit ap, logic [AW-1:0] a, logic [DW-1:0] d,
                        output logic [P-1:0] rdy, output logic [P-1:0] rv,
                        output logic [DW-1:0] rd);
        @(negedge clk); idle_all(); drive(p, wr, ap, a, d);
        #1 rdy = req_ready;
        @(negedge clk); idle_all();
        #1 rv = rsp_valid; rd = rsp_rdata;
    endtask

    task automatic load_gen(int p, logic [AW-1:0] b, int s, int l);
        @(negedge clk); idle_all();
        cfg_load[p] = 1'b1; cfg_base = b; cfg_stride = AW'(s); cfg_len = (AW+1)'(l);
        @(negedge clk); cfg_load = '0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R9 rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R9 ready idle after reset", 32'(req_ready), 0);
    endtask

    task automatic t_direct();
        logic [P-1:0] rdy, rv; logic [DW-1:0] rd;
        xfer(1, 1, 0, 11'd9, 16'h1111, rdy, rv, rd); model[9] = 16'h1111;
        chk("R10 write ready", 32'(rdy), 32'b0010);
        chk("R7 write gives no response", 32'(rv), 0);
        xfer(0, 0, 0, 11'd9, 16'h0, rdy, rv, rd);
        chk("R2 read back across ports", 32'(rd), 32'h1111);
        chk("R7 response only on reader", 32'(rv), 32'b0001);
    endtask

    task automatic t_disabled();
        logic [P-1:0] rdy, rv; logic [DW-1:0] rd;
        port_en[3] = 1'b0;
        @(negedge clk); idle_all(); drive(3, 1, 0, 11'd9, 16'h5555);
        for (int k = 0; k < 3; k++) begin
            #1 chk("R1 off port not ready", 32'(req_ready), 0);
            @(negedge clk);
        end
        idle_all();
        #1 chk("R1 off port no response", 32'(rsp_valid), 0);
        xfer(0, 0, 0, 11'd9, 16'h0, rdy, rv, rd);
        chk("R1 off port write ignored", 32'(rd), 32'h1111);
        port_en[3] = 1'b1;
    endtask

    task automatic t_rotation();
        do_reset();
        @(negedge clk);
        for (int p = 0; p < P; p++) drive(p, 0, 0, 11'd9, 16'h0);
        for (int k = 0; k < 8; k++) begin
            #1 chk("R3 rotation grant", 32'(req_ready), 32'(1 << (k % 4)));
            @(negedge clk);
        end
        idle_all();
    endtask

    task automatic t_priority();
        do_reset();
        port_hi[3] = 1'b1;
        @(negedge clk);
        for (int p = 0; p < P; p++) drive(p, 0, 0, 11'd9, 16'h0);
        for (int k = 0; k < 3; k++) begin
            #1 chk("R4 high level wins", 32'(req_ready), 32'b1000);
            @(negedge clk);
        end
        port_hi = '0;
        #1 chk("R3 oldest wins after priority drop", 32'(req_ready), 32'b0001);
        @(negedge clk); idle_all();
    endtask

    task automatic t_idle_order();
        logic [P-1:0] rdy, rv; logic [DW-1:0] rd;
        do_reset();
        xfer(2, 0, 0, 11'd9, 16'h0, rdy, rv, rd);
        repeat (3) @(negedge clk);
        drive(0, 0, 0, 11'd9, 16'h0); drive(2, 0, 0, 11'd9, 16'h0);
        #1 chk("R8 order kept over idle", 32'(req_ready), 32'b0001);
        @(negedge clk);
        #1 chk("R8 served port becomes newest", 32'(req_ready), 32'b0100);
        @(negedge clk); idle_all();
    endtask

    task automatic t_agen();
        logic [P-1:0] rdy, rv; logic [DW-1:0] rd;
        int off;
        port_mode[2*1 +: 2] = 2'd1;
        load_gen(1, 11'd100, 3, 7);
        off = 0;
        for (int k = 0; k < 10; k++) begin
            xfer(1, 1, 0, 11'd0, 16'hA000 + 16'(k), rdy, rv, rd);
            model[100 + off] = 16'hA000 + 16'(k);
            off = (off + 3) % 7;
        end
        chk("R5 generator write ready", 32'(rdy), 32'b0010);
        for (int a = 100; a < 107; a++) begin
            xfer(0, 0, 0, AW'(a), 16'h0, rdy, rv, rd);
            chk("R5 positive stride wrap", 32'(rd), 32'(model[a]));
        end
        load_gen(1, 11'd200, -2, 5);
        off = 0;
        for (int k = 0; k < 5; k++) begin
            xfer(1, 1, 0, 11'd0, 16'hB000 + 16'(k), rdy, rv, rd);
            model[200 + off] = 16'hB000 + 16'(k);
            off = (off - 2 + 5) % 5;
        end
        for (int k = 0; k < 5; k++) begin
            xfer(1, 0, 0, 11'd0, 16'h0, rdy, rv, rd);
            chk("R5 negative stride read", 32'(rd), 32'(model[200 + off]));
            chk("R7 generator response tag", 32'(rv), 32'b0010);
            off = (off - 2 + 5) % 5;
        end
        port_mode[2*1 +: 2] = 2'd0;
    endtask

    task automatic t_split();
        logic [P-1:0] rdy, rv; logic [DW-1:0] rd;
        port_mode[2*2 +: 2] = 2'd2;
        @(negedge clk); idle_all();
        drive(2, 0, 1, 11'd0, 16'd300);
        drive(0, 0, 0, 11'd100, 16'h0);
        #1 chk("R6 address phase and array grant together", 32'(req_ready), 32'b0101);
        @(negedge clk); idle_all();
        #1 chk("R6 only array read responds", 32'(rsp_valid), 32'b0001);
        chk("R6 concurrent read data", 32'(rsp_rdata), 32'(model[100]));
        xfer(2, 1, 0, 11'd7, 16'hBEEF, rdy, rv, rd); model[300] = 16'hBEEF;
        chk("R6 data phase ready", 32'(rdy), 32'b0100);
        xfer(0, 0, 0, 11'd300, 16'h0, rdy, rv, rd);
        chk("R6 data phase used latched address", 32'(rd), 32'hBEEF);
        xfer(2, 0, 1, 11'd0, 16'd104, rdy, rv, rd);
        chk("R6 address phase gives no response", 32'(rv), 0);
        xfer(2, 0, 0, 11'd0, 16'h0, rdy, rv, rd);
        chk("R6 split read data", 32'(rd), 32'(model[104]));
        chk("R7 split response tag", 32'(rv), 32'b0100);
        port_mode[2*2 +: 2] = 2'd0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle_all();
        port_en = '1; port_hi = '0; port_mode = '0;
        cfg_base = '0; cfg_stride = '0; cfg_len = '0;
        t_reset();
        t_direct();
        t_disabled();
        t_agen();
        t_split();
        t_rotation();
        t_priority();
        t_idle_order();
        finish_run();
    end
endmodule